// File: doc/BRIEF.md
# UART Receive Buffer with Error Capture

This block sits between a UART deserializer and the register bus of a peripheral. The deserializer delivers each received character as a 12-bit entry: the data byte sits in bits 7:0 and four error flags sit in bits 11:8. The block queues these entries. Software drains them through a data register, and each read pops one entry.

When software reads a character, the error bits of that character are copied into a separate status register. Software can therefore check the status after each read and clear it with any write. A line-control register chooses between two modes: a 16-deep queue, or a single holding register. Changing that mode throws away whatever is buffered. A receive interrupt rises when the fill level reaches a programmable trigger level. It falls when a read takes the fill level back below that level.

Top module: `uart_rx_buffer`

## Requirements
- R1: The buffer holds up to DEPTH (16) entries when bit 4 of the line-control register (address 3) is 1. It holds exactly one entry when that bit is 0. After reset the line-control register is 0.
- R2: The full flag (bit 1 of the flag register at address 2) is 1 when the fill level reaches the capacity. In single-entry mode this happens after any accepted push.
- R3: An accepted push clears the empty flag (bit 0 of the flag register) and adds one entry. Entries are read back in arrival order.
- R4: A read of the data register (address 0) returns the whole 12-bit head entry and pops it. In the same cycle, bits 11:8 of that entry are copied into the status register.
- R5: A read of the status register (address 1) returns, in bits 3:0, the error bits copied by the latest data read.
- R6: Any write to address 1 clears the status register to 0, whatever data is written.
- R7: A line-control write that changes bit 4 discards all buffered entries, sets the empty flag and drops the interrupt. A write that leaves bit 4 unchanged keeps the contents.
- R8: The interrupt output rises when a push brings the fill level up to the trigger level. The trigger register is at address 4 and resets to 8; in single-entry mode the trigger level in effect is 1. The output falls on a data read that takes the fill level from the trigger level to one below it.
- R9: Writes to the flag register change nothing.
- R10: A data read while the buffer is empty returns the last value read. It leaves the fill level, the flags and the status unchanged.
- R11: Every pop clears the full flag. A pop that empties the buffer sets the empty flag.
- R12: A push into a full buffer is discarded and sets bit 3 (overrun) of the status register.
- R13: After reset the flags read empty = 1 and full = 0, the status reads 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | A received character is offered this cycle |
| rx_char | input | 12 | Character: data in bits 7:0, error flags in bits 11:8 |
| bus_addr | input | 3 | Register select (0 data, 1 status, 2 flags, 3 line control, 4 trigger) |
| bus_rd | input | 1 | Read strobe; a data read pops at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 12 | Read data for the selected register, combinational |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The properties assume that the bus makes at most one access per cycle, so a read strobe and a write strobe are never high together. Several properties also leave out cycles in which a character push coincides with the bus access they reason about. The stimulus keeps to both rules because every task drives only one kind of operation at a time. The trigger level is always programmed between 1 and the queue depth, which is the range in which the interrupt behaviour is defined.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  localparam int DATA_W  = 8;
  localparam int ERR_W   = 4;
  localparam int ENTRY_W = DATA_W + ERR_W;
  localparam int ADDR_W  = 3;
  localparam int FIFO_EN_BIT = 4;
  localparam int OVR_BIT     = 3;

  localparam logic [ADDR_W-1:0] A_DATA    = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LINECTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIGGER = 3'd4;
endpackage

// File: rtl/uart_rxb_store.sv
module uart_rxb_store #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 12,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_en,
  input  logic               pop_en,
  input  logic               flush,
  input  logic [ENTRY_W-1:0] wr_data,
  output logic [ENTRY_W-1:0] head,
  output logic [CNT_W-1:0]   count
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]   rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_en) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_en)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_en, pop_en})
        2'b10:   cnt_d = cnt_q + CNT_W'(1);
        2'b01:   cnt_d = cnt_q - CNT_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en && !flush) mem_q[wr_ptr_q] <= wr_data;
  end

  assign head  = mem_q[rd_ptr_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_rxb_irq.sv
module uart_rxb_irq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic             pop_en,
  input  logic             flush,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trig_level,
  output logic             irq
);
  logic irq_q, irq_d;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = count + CNT_W'(1);

  always_comb begin
    irq_d = irq_q;
    if (flush)
      irq_d = 1'b0;
    else if (push_en && !pop_en && (cnt_inc == trig_level))
      irq_d = 1'b1;
    else if (pop_en && !push_en && (count == trig_level))
      irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/uart_rxb_ctl.sv
module uart_rxb_ctl
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TRIG_RESET = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_push,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [ENTRY_W-1:0] head,
  input  logic [CNT_W-1:0]   count,
  output logic               push_en,
  output logic               pop_en,
  output logic               flush,
  output logic               full,
  output logic               empty,
  output logic               fifo_en,
  output logic [ERR_W-1:0]   status,
  output logic [CNT_W-1:0]   trig_level,
  output logic [ENTRY_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] CAP_FIFO = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);

  logic [DATA_W-1:0]  lcr_q, lcr_d;
  logic [CNT_W-1:0]   trig_q, trig_d;
  logic [ERR_W-1:0]   stat_q, stat_d;
  logic [ENTRY_W-1:0] last_q, last_d;
  logic [CNT_W-1:0]   capacity;
  logic               wr_lcr, wr_stat, wr_trig, rd_data, drop;

  assign fifo_en  = lcr_q[FIFO_EN_BIT];
  assign capacity = fifo_en ? CAP_FIFO : CAP_ONE;
  assign full     = (count >= capacity);
  assign empty    = (count == '0);

  assign wr_lcr   = bus_wr && (bus_addr == A_LINECTL);
  assign wr_stat  = bus_wr && (bus_addr == A_STATUS);
  assign wr_trig  = bus_wr && (bus_addr == A_TRIGGER);
  assign rd_data  = bus_rd && (bus_addr == A_DATA);

  assign flush    = wr_lcr && (bus_wdata[FIFO_EN_BIT] != lcr_q[FIFO_EN_BIT]);
  assign pop_en   = rd_data && !empty && !flush;
  assign push_en  = rx_push && !full && !flush;
  assign drop     = rx_push && full && !flush;

  assign trig_level = fifo_en ? trig_q : CAP_ONE;
  assign status     = stat_q;

  always_comb begin
    lcr_d  = wr_lcr  ? bus_wdata : lcr_q;
    trig_d = wr_trig ? CNT_W'(bus_wdata) : trig_q;
    last_d = pop_en  ? head : last_q;
    if (pop_en)       stat_d = head[ENTRY_W-1:DATA_W];
    else if (wr_stat) stat_d = '0;
    else              stat_d = stat_q;
    if (drop) stat_d[OVR_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q  <= '0;
      trig_q <= CNT_W'(TRIG_RESET);
      stat_q <= '0;
      last_q <= '0;
    end else begin
      if (wr_lcr)  lcr_q  <= lcr_d;
      if (wr_trig) trig_q <= trig_d;
      stat_q <= stat_d;
      if (pop_en)  last_q <= last_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:    rdata = empty ? last_q : head;
      A_STATUS:  rdata = ENTRY_W'(stat_q);
      A_FLAGS:   rdata = ENTRY_W'({full, empty});
      A_LINECTL: rdata = ENTRY_W'(lcr_q);
      A_TRIGGER: rdata = ENTRY_W'(trig_q);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int TRIG_RESET = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_push,
  input  logic [ENTRY_W-1:0] rx_char,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [ENTRY_W-1:0] bus_rdata,
  output logic               rx_irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic               push_w, pop_w, flush_w, full_w, empty_w, fifo_en_w;
  logic [ENTRY_W-1:0] head_w;
  logic [CNT_W-1:0]   cnt_w, trig_w;
  logic [ERR_W-1:0]   status_w;

  uart_rxb_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) i_store (
    .clk(clk), .rst_n(rst_n), .push_en(push_w), .pop_en(pop_w),
    .flush(flush_w), .wr_data(rx_char), .head(head_w), .count(cnt_w)
  );

  uart_rxb_ctl #(.DEPTH(DEPTH), .TRIG_RESET(TRIG_RESET)) i_ctl (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .head(head_w), .count(cnt_w), .push_en(push_w), .pop_en(pop_w),
    .flush(flush_w), .full(full_w), .empty(empty_w), .fifo_en(fifo_en_w),
    .status(status_w), .trig_level(trig_w), .rdata(bus_rdata)
  );

  uart_rxb_irq #(.CNT_W(CNT_W)) i_irq (
    .clk(clk), .rst_n(rst_n), .push_en(push_w), .pop_en(pop_w),
    .flush(flush_w), .count(cnt_w), .trig_level(trig_w), .irq(rx_irq)
  );
endmodule

// File: rtl/uart_rxb_checker.sv
module uart_rxb_checker
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_push,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_fifo_bit,
  input logic              rx_irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              fifo_en,
  input logic              full,
  input logic              empty,
  input logic [ERR_W-1:0]  status
);
  localparam logic [CNT_W-1:0] CAP_FIFO = CNT_W'(DEPTH);

  AST_CNT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (fifo_en ? CAP_FIFO : CNT_W'(1))); // R1

  AST_SINGLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !empty) |-> full); // R2

  AST_PUSH_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !full && !bus_wr) |=> !empty); // R3

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STATUS && !rx_push) |=> (status == '0)); // R6

  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_LINECTL && (wr_fifo_bit != fifo_en)) |=> (empty && !rx_irq)); // R7

  AST_IRQ_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rx_push)); // R8

  AST_FLAGS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FLAGS && !rx_push) |=> ($stable(cnt) && $stable(status))); // R9

  AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && empty && !rx_push) |=> ($stable(cnt) && $stable(status))); // R10

  AST_POP_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_DATA && !empty && !rx_push) |=> !full); // R11

  AST_DROP_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && full && !bus_rd && !bus_wr) |=> (status[OVR_BIT] && $stable(cnt))); // R12
endmodule

bind uart_rx_buffer uart_rxb_checker #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .wr_fifo_bit(bus_wdata[4]),
  .rx_irq(rx_irq), .cnt(cnt_w), .fifo_en(fifo_en_w), .full(full_w),
  .empty(empty_w), .status(status_w)
);

// File: tb/test_uart_rx_buffer.sv
module test_uart_rx_buffer;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        rx_push;
  logic [11:0] rx_char;
  logic [2:0]  bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [11:0] bus_rdata;
  logic        rx_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  uart_rx_buffer i_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_char(rx_char),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] v);
    @(negedge clk);
    rx_push = 1'b1; rx_char = v;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [11:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [11:0] v;
    rd(3'd2, v); check("R13 flags after reset", v, 12'h001);
    rd(3'd1, v); check("R13 status after reset", v, 12'h000);
    check("R13 irq after reset", {11'd0, rx_irq}, 12'h000);
    rd(3'd4, v); check("R8 trigger reset value", v, 12'h008);
    rd(3'd3, v); check("R1 line control reset", v, 12'h000);
  endtask

  task automatic t_single;
    logic [11:0] v;
    push(12'h341);
    rd(3'd2, v); check("R2 single mode full after one push", v, 12'h002);
    check("R8 irq at single-mode trigger", {11'd0, rx_irq}, 12'h001);
    push(12'h0AA);
    rd(3'd1, v); check("R12 overrun on push when full", v, 12'h008);
    rd(3'd0, v); check("R4 data read returns entry", v, 12'h341);
    rd(3'd1, v); check("R5 status holds captured error bits", v, 12'h003);
    rd(3'd2, v); check("R11 pop to zero sets empty", v, 12'h001);
    check("R8 irq cleared by read", {11'd0, rx_irq}, 12'h000);
  endtask

  task automatic t_empty_read;
    logic [11:0] v;
    rd(3'd0, v); check("R10 empty read returns last value", v, 12'h341);
    rd(3'd1, v); check("R10 status unchanged by empty read", v, 12'h003);
    rd(3'd2, v); check("R10 flags unchanged by empty read", v, 12'h001);
    wr(3'd1, 8'h00);
    rd(3'd1, v); check("R6 status cleared by write", v, 12'h000);
  endtask

  task automatic t_fifo;
    logic [11:0] v;
    wr(3'd3, 8'h10);
    wr(3'd4, 8'd4);
    for (int i = 0; i < 16; i++) begin
      push(12'h0A0 + 12'(i));
      if (i == 2) check("R8 irq low below trigger", {11'd0, rx_irq}, 12'h000);
      if (i == 3) check("R8 irq high at trigger", {11'd0, rx_irq}, 12'h001);
      if (i == 14) begin
        rd(3'd2, v); check("R1 not full at 15 entries", v, 12'h000);
      end
    end
    rd(3'd2, v); check("R2 full at 16 entries", v, 12'h002);
    push(12'h5FF);
    rd(3'd1, v); check("R12 overrun in fifo mode", v, 12'h008);
    for (int k = 0; k < 16; k++) begin
      rd(3'd0, v); check("R3 order of entries", v, 12'h0A0 + 12'(k));
      if (k == 0) begin
        rd(3'd2, v); check("R11 pop clears full", v, 12'h000);
        rd(3'd1, v); check("R4 status recaptured on read", v, 12'h000);
      end
      if (k == 11) check("R8 irq still high at trigger", {11'd0, rx_irq}, 12'h001);
      if (k == 12) check("R8 irq cleared below trigger", {11'd0, rx_irq}, 12'h000);
    end
    rd(3'd2, v); check("R11 empty after draining", v, 12'h001);
  endtask

  task automatic t_flush;
    logic [11:0] v;
    push(12'h0B1); push(12'h0B2); push(12'h0B3);
    wr(3'd3, 8'h11);
    rd(3'd2, v); check("R7 same mode keeps contents", v, 12'h000);
    rd(3'd0, v); check("R7 head kept after same-mode write", v, 12'h0B1);
    wr(3'd3, 8'h01);
    rd(3'd2, v); check("R7 mode change empties buffer", v, 12'h001);
    rd(3'd0, v); check("R7 discarded data not readable", v, 12'h0B1);
    push(12'h0C5);
    check("R8 irq in single mode", {11'd0, rx_irq}, 12'h001);
    wr(3'd3, 8'h10);
    check("R7 mode change drops irq", {11'd0, rx_irq}, 12'h000);
    rd(3'd2, v); check("R7 flush after mode change", v, 12'h001);
  endtask

  task automatic t_flag_write;
    logic [11:0] v;
    push(12'h07D);
    wr(3'd2, 8'hFF);
    rd(3'd2, v); check("R9 flags ignore writes", v, 12'h000);
    rd(3'd0, v); check("R9 data intact after flag write", v, 12'h07D);
    rd(3'd2, v); check("R11 empty after last pop", v, 12'h001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_push = 1'b0; rx_char = '0;
    bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_empty_read();
    t_fifo();
    t_flush();
    t_flag_write();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule